// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block is a bit-serial keystream generator built from three linear feedback shift registers of 19, 22 and 23 stages. Each register has one stage set aside as its clocking bit. When a step is requested, the block forms the majority value of the three clocking bits. Only the registers whose clocking bit equals that majority shift, and the others keep their contents. Because of this irregular clocking, at least two registers advance on every step, and all three advance when the clocking bits agree.

The output keystream bit is the XOR of the top stages of the three registers after the step. It appears together with a valid strobe one cycle after the step request. Software or a surrounding controller writes the initial contents of the registers in parallel through seed ports, then issues one step per wanted keystream bit. Key and frame-number mixing and any framing sit outside this block.

Top module: `maj_stream_core`

## Requirements
- R1: After reset, `ks_valid` and `ks_bit` are 0 and all three registers hold zero.
- R2: When `load` is 1 on a clock edge, the registers take `seed_a`, `seed_b` and `seed_c` (bit i of a seed goes to stage i). Any `step` in that cycle is ignored, and `ks_valid` is 0 in the following cycle.
- R3: On a step, the majority m of the clocking bits (A stage 8, B stage 10, C stage 10) is (a&b)|(b&c)|(a&c). A register shifts exactly when its clocking bit XOR m is 0, and otherwise it holds its contents.
- R4: Each accepted step advances at least two registers.
- R5: A shift moves stage i to stage i+1 and loads stage 0 with the XOR of the tapped stages. A taps stages 13,16,17,18; B taps 20,21; C taps 7,20,21,22 (0-based).
- R6: One cycle after an accepted step, `ks_valid` is 1 and `ks_bit` is the XOR of stage 18 of A, stage 21 of B and stage 22 of C as they stand after that step. When `ks_valid` is 0, `ks_bit` is 0.
- R7: In a cycle with neither `load` nor `step`, no register changes and `ks_valid` is 0 in the following cycle.
- R8: If all registers are loaded with zero, every later keystream bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel seed load; takes priority over step |
| seed_a | input | 19 | Initial contents of register A |
| seed_b | input | 22 | Initial contents of register B |
| seed_c | input | 23 | Initial contents of register C |
| step | input | 1 | Request one keystream step |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | Keystream bit is valid this cycle |

## Verification
The assertions treat `load` and `step` as free inputs that may both be high. They treat a simultaneous load and step as a load alone, and they assume no particular seed values. The stimulus therefore mixes random seeds, loads landing on top of steps, and idle gaps. It also applies directed seeds: all zero, all clocking bits equal, and a single clocking bit off the majority. Every output cycle is compared against a bench model of the three registers.

// File: rtl/msc_pkg.sv
package msc_pkg;
    localparam int NREG   = 3;
    localparam int MAXLEN = 23;
    localparam int LEN_A  = 19;
    localparam int LEN_B  = 22;
    localparam int LEN_C  = 23;

    localparam int REG_LEN [NREG] = '{LEN_A, LEN_B, LEN_C};
    localparam int CLK_POS [NREG] = '{8, 10, 10};

    // feedback tap masks, bit i set when stage i feeds the XOR
    localparam logic [MAXLEN-1:0] TAP_MASK [NREG] = '{
        23'h072000,  // 13,16,17,18
        23'h300000,  // 20,21
        23'h700080   // 7,20,21,22
    };

    typedef struct packed {
        logic ks;
        logic vld;
    } out_state_t;
endpackage

// File: rtl/msc_lane.sv
module msc_lane #(
    parameter int LEN = 19,
    parameter int CPOS = 8,
    parameter logic [LEN-1:0] TAPS = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] seed,
    input  logic           advance,
    output logic           clk_bit,
    output logic           msb_next
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } lane_t;

    lane_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.bits = seed;
        end else if (advance) begin
            s_d.bits = {s_q.bits[LEN-2:0], ^(s_q.bits & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_bit  = s_q.bits[CPOS];
    assign msb_next = s_d.bits[LEN-1];
endmodule

// File: rtl/msc_vote.sv
module msc_vote #(
    parameter int N = 3
) (
    input  logic [N-1:0] cbits,
    output logic [N-1:0] agree
);
    logic maj;

    assign maj = (cbits[0] & cbits[1]) | (cbits[1] & cbits[2]) | (cbits[0] & cbits[2]);

    for (genvar i = 0; i < N; i++) begin : g_agree
        assign agree[i] = ~(cbits[i] ^ maj);
    end
endmodule

// File: rtl/maj_stream_core.sv
module maj_stream_core
    import msc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_A-1:0] seed_a,
    input  logic [LEN_B-1:0] seed_b,
    input  logic [LEN_C-1:0] seed_c,
    input  logic             step,
    output logic             ks_bit,
    output logic             ks_valid
);
    logic [MAXLEN-1:0] seed_pad [NREG];
    logic [NREG-1:0]   cbits;
    logic [NREG-1:0]   agree;
    logic [NREG-1:0]   adv;
    logic [NREG-1:0]   msb_nx;
    logic              go;

    out_state_t o_d, o_q;

    assign seed_pad[0] = MAXLEN'(seed_a);
    assign seed_pad[1] = MAXLEN'(seed_b);
    assign seed_pad[2] = seed_c;

    assign go  = step & ~load;
    assign adv = agree & {NREG{go}};

    msc_vote #(.N(NREG)) u_vote (
        .cbits (cbits),
        .agree (agree)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_lane
        localparam int L = REG_LEN[i];
        localparam logic [MAXLEN-1:0] FULL_MASK = TAP_MASK[i];
        logic [L-1:0] seed_w;
        assign seed_w = seed_pad[i][L-1:0];
        msc_lane #(
            .LEN  (L),
            .CPOS (CLK_POS[i]),
            .TAPS (FULL_MASK[L-1:0])
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .seed     (seed_w),
            .advance  (adv[i]),
            .clk_bit  (cbits[i]),
            .msb_next (msb_nx[i])
        );
    end

    always_comb begin
        o_d     = '0;
        o_d.vld = go;
        o_d.ks  = go & (^msb_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ks_bit   = o_q.ks;
    assign ks_valid = o_q.vld;
endmodule

// File: rtl/msc_checker.sv
module msc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic       step,
    input logic [2:0] adv,
    input logic       ks_bit,
    input logic       ks_valid
);
    assert_valid_after_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ks_valid);

    assert_bit_zero_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid |-> !ks_bit);

    assert_load_blocks_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ks_valid);

    assert_no_step_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !ks_valid);

    assert_no_shift_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && !load) |-> (adv == 3'b000));

    assert_two_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> ($countones(adv) >= 2));
endmodule

bind maj_stream_core msc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .adv      (adv),
    .ks_bit   (ks_bit),
    .ks_valid (ks_valid)
);

// File: tb/maj_stream_core_bench.sv
module maj_stream_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [18:0] seed_a = '0;
    logic [21:0] seed_b = '0;
    logic [22:0] seed_c = '0;
    logic        step = 1'b0;
    logic        ks_bit;
    logic        ks_valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [18:0] ma = '0;
    logic [21:0] mb = '0;
    logic [22:0] mc = '0;
    logic        e_vld = 1'b0;
    logic        e_ks = 1'b0;

    always #2 clk = ~clk;

    maj_stream_core u_maj_stream_core (
        .clk(clk), .rst_n(rst_n), .load(load),
        .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
        .step(step), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model of one step (R3, R5)
    task automatic model_step();
        logic a, b, c, m;
        a = ma[8]; b = mb[10]; c = mc[10];
        m = (a & b) | (b & c) | (a & c);
        if (a == m) ma = {ma[17:0], ma[18] ^ ma[17] ^ ma[16] ^ ma[13]};
        if (b == m) mb = {mb[20:0], mb[21] ^ mb[20]};
        if (c == m) mc = {mc[21:0], mc[22] ^ mc[21] ^ mc[20] ^ mc[7]};
    endtask

    task automatic tick(input bit ld, input bit st, input logic [18:0] sa,
                        input logic [21:0] sb, input logic [22:0] sc, input string tag);
        load = ld; step = st; seed_a = sa; seed_b = sb; seed_c = sc;
        @(posedge clk);
        #1;
        if (ld) begin
            ma = sa; mb = sb; mc = sc; e_vld = 1'b0; e_ks = 1'b0;
        end else if (st) begin
            model_step();
            e_vld = 1'b1;
            e_ks = ma[18] ^ mb[21] ^ mc[22];
        end else begin
            e_vld = 1'b0; e_ks = 1'b0;
        end
        chk(ks_valid == e_vld, {tag, " valid"}, int'(ks_valid), int'(e_vld));
        chk(ks_bit == e_ks, {tag, " bit"}, int'(ks_bit), int'(e_ks));
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        int seed_v;
        seed_v = $urandom(32'h5eed1234);
        #7;
        // R1: reset state
        chk(ks_valid == 1'b0, "R1 valid at reset", int'(ks_valid), 0);
        chk(ks_bit == 1'b0, "R1 bit at reset", int'(ks_bit), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: stepping from the reset (zero) state gives zeros
        tick(0, 1, '0, '0, '0, "R1 step from reset");

        // R8: all-zero load stays zero
        tick(1, 0, '0, '0, '0, "R8 load zero");
        for (int i = 0; i < 20; i++) tick(0, 1, '0, '0, '0, "R8 zero stream");

        // R3: all clocking bits equal, all advance
        tick(1, 0, 19'h00100, 22'h000400, 23'h000400, "R3 load equal clocks");
        for (int i = 0; i < 30; i++) tick(0, 1, '0, '0, '0, "R3 all agree");

        // R3: one clocking bit off the majority
        tick(1, 0, 19'h00100, 22'h000000, 23'h400000, "R3 load odd clock");
        for (int i = 0; i < 30; i++) tick(0, 1, '0, '0, '0, "R3 minority holds");

        // R5: single tap bits exercise feedback
        tick(1, 0, 19'h40000, 22'h200000, 23'h400080, "R5 load tap seed");
        for (int i = 0; i < 60; i++) tick(0, 1, '0, '0, '0, "R5 feedback");

        // R2: load with step at once, step ignored
        tick(1, 1, 19'h5a5a5, 22'h2c3d4e, 23'h1f2e3d, "R2 load with step");
        for (int i = 0; i < 10; i++) tick(0, 1, '0, '0, '0, "R2 after load");

        // R7: idle cycles hold state
        for (int i = 0; i < 5; i++) tick(0, 0, '0, '0, '0, "R7 idle");
        for (int i = 0; i < 10; i++) tick(0, 1, '0, '0, '0, "R7 resume");

        // R4 R6: constrained random
        for (int i = 0; i < 4000; i++) begin
            bit ld, st;
            ld = ($urandom_range(63) == 0);
            st = ($urandom_range(3) != 0);
            tick(ld, st, 19'($urandom), 22'($urandom), 23'($urandom), "R4 R6 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule